// File: doc/BRIEF.md
# Delta Block Encoding Register

This block is a burst-form delta modulator built around an N-bit bidirectional shift register. One end of the register takes a constant one and the other end takes a constant zero. On each enabled clock a single direction bit decides which way the register shifts. The register therefore holds a thermometer-coded level that climbs or falls by exactly one step, with saturation at both ends. The level is read as the count of ones in the register, and the block also keeps it as a binary count.

The direction bit comes from one of two places. It can come from an external burst input, so the block decodes a delta stream into a level. It can also come from a built-in encoder that compares a binary target sample with the current level, so the block produces a delta stream that tracks the target. The emitted bit is always visible on an output. A steady target cannot be held exactly: the level keeps swinging one step around it, and this granular noise is expected behaviour.

Top module: `delta_block_enc`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register bit to 0 and the binary level to 0.
- R2: On an enabled clock with emitted bit 1, the register shifts toward its high end. Bit 0 takes a constant 1 and each bit i>0 takes the old bit i-1. The level rises by one.
- R3: On an enabled clock with emitted bit 0, the register shifts toward its low end. Bit N-1 takes a constant 0 and each bit i<N-1 takes the old bit i+1. The level falls by one.
- R4: At level N (all ones), an up step leaves the register and the level unchanged.
- R5: At level 0 (all zeros), a down step leaves the register and the level unchanged.
- R6: The register is always a contiguous thermometer code. Bits [level-1:0] are 1 and all higher bits are 0, so the binary level equals the count of ones.
- R7: With `enable` low, the register and the level hold their values whatever the other inputs are.
- R8: With `selfEncode` high, the emitted bit is 1 when the unsigned binary `target` is greater than the current level, and 0 otherwise.
- R9: With `selfEncode` low, the emitted bit equals `dirIn`.
- R10: In encoder mode with a constant target T, where 1 <= T <= N, the level settles into an alternation between T-1 and T and never stays still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Step enable; when low, the state is frozen |
| selfEncode | input | 1 | 1 selects the built-in encoder, 0 selects `dirIn` |
| dirIn | input | 1 | External burst bit (1 means step up) |
| target | input | $clog2(N+1) | Unsigned binary target sample for the encoder |
| thermo | output | N | Thermometer register contents |
| level | output | $clog2(N+1) | Binary count of ones in the register |
| bitOut | output | 1 | Direction bit applied at the next edge |

## Verification
The bench builds the block with N = 6, which gives a 3-bit level and target. With N = 6, both saturation ends are reached within a few steps. The 3-bit target can also exceed N (value 7), which drives the encoder against the full limit. The short register lets a single run walk the level fully up and fully down, freeze it mid-range, and hold the encoder on a steady target long enough to see the one-step granular swing. The run also includes a reset in the middle of activity.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic stepEn;  // apply a step on this edge
    logic stepUp;  // 1: shift up (fill one), 0: shift down (fill zero)
  } stepCmd_t;
endpackage

// File: rtl/dbe_ctrl.sv
module dbe_ctrl
  import dbe_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             enable,
  input  logic             selfEncode,
  input  logic             dirIn,
  input  logic [LVL_W-1:0] target,
  input  logic [LVL_W-1:0] level,
  output stepCmd_t         cmd,
  output logic             bitOut
);
  logic encBit;

  // Encoder: step up only while the target lies strictly above the level
  always_comb encBit = (target > level);

  always_comb begin
    bitOut     = selfEncode ? encBit : dirIn;
    cmd.stepEn = enable;
    cmd.stepUp = bitOut;
  end
endmodule

// File: rtl/dbe_datapath.sv
module dbe_datapath
  import dbe_pkg::*;
#(
  parameter int N     = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  stepCmd_t         cmd,
  output logic [N-1:0]     thermo,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(N);

  always_ff @(posedge clk) begin
    if (rst) begin
      thermo <= '0;
      level  <= '0;
    end else if (cmd.stepEn) begin
      if (cmd.stepUp) begin
        thermo <= {thermo[N-2:0], 1'b1};
        if (level != FULL) level <= level + 1'b1;
      end else begin
        thermo <= {1'b0, thermo[N-1:1]};
        if (level != '0) level <= level - 1'b1;
      end
    end
  end

  // R6
  thermo_contig_chk: assert property (@(posedge clk) disable iff (rst)
    ((thermo & (thermo + 1'b1)) == '0) && (int'(level) == $countones(thermo)));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.stepEn |=> ($stable(thermo) && $stable(level)));

  // R4
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.stepEn && cmd.stepUp && level == FULL) |=> ($stable(thermo) && $stable(level)));

  // R5
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.stepEn && !cmd.stepUp && level == '0) |=> ($stable(thermo) && $stable(level)));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.stepEn && cmd.stepUp && level != FULL) |=> (level == $past(level) + 1'b1));

  // R3
  step_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.stepEn && !cmd.stepUp && level != '0) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/delta_block_enc.sv
module delta_block_enc
  import dbe_pkg::*;
#(
  parameter int N = 8,
  localparam int LVL_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             selfEncode,
  input  logic             dirIn,
  input  logic [LVL_W-1:0] target,
  output logic [N-1:0]     thermo,
  output logic [LVL_W-1:0] level,
  output logic             bitOut
);
  stepCmd_t cmd;

  dbe_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .enable(enable), .selfEncode(selfEncode), .dirIn(dirIn),
    .target(target), .level(level), .cmd(cmd), .bitOut(bitOut)
  );

  dbe_datapath #(.N(N), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .thermo(thermo), .level(level)
  );

  // R9
  ext_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !selfEncode && dirIn && level != LVL_W'(N)) |=> (level != $past(level) - 1'b1) && (level != $past(level)));
endmodule

// File: tb/delta_block_enc_tb.sv
module delta_block_enc_tb;
  localparam int N = 6;
  localparam int LW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst, enable, selfEncode, dirIn;
  logic [LW-1:0] target;
  logic [N-1:0] thermo;
  logic [LW-1:0] level;
  logic bitOut;

  int vectors = 0;
  int miscompares = 0;
  int lvl = 0;
  bit finished = 0;
  int prevLvl = -1;

  always #10 clk = ~clk;

  delta_block_enc #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .selfEncode(selfEncode),
    .dirIn(dirIn), .target(target), .thermo(thermo), .level(level), .bitOut(bitOut)
  );

  function automatic logic [N-1:0] thermoOf(int v);
    logic [N-1:0] t = '0;
    for (int i = 0; i < v; i++) t[i] = 1'b1;
    return t;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit en, bit mode, bit d, int tgt, string tag, bit doCheck = 1);
    int expBit;
    @(negedge clk);
    rst = r; enable = en; selfEncode = mode; dirIn = d; target = LW'(tgt);
    #1;
    if (doCheck) begin
      expBit = mode ? ((tgt > lvl) ? 1 : 0) : int'(d);
      cmp(tag, "bitOut", int'(bitOut), expBit);
      cmp(tag, "level", int'(level), lvl);
      // R6 thermometer contents against the behavioural level
      cmp("R6", "thermo", int'(thermo), int'(thermoOf(lvl)));
    end
    @(posedge clk);
    if (r) lvl = 0;
    else if (en) begin
      expBit = mode ? ((tgt > lvl) ? 1 : 0) : int'(d);
      if (expBit == 1) lvl = (lvl < N) ? lvl + 1 : N;
      else lvl = (lvl > 0) ? lvl - 1 : 0;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1; enable = 0; selfEncode = 0; dirIn = 0; target = '0;
    step(1, 0, 0, 0, 0, "R1", 0);
    step(1, 1, 0, 1, 0, "R1", 0);
    // R1 reset state
    step(0, 0, 0, 1, 0, "R1");
    // R2 climbing with external bit
    for (int i = 0; i < N; i++) step(0, 1, 0, 1, 0, "R2");
    // R4 up steps at full
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, "R4");
    // R7 frozen at full while asking for down
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R7");
    // R3 falling
    for (int i = 0; i < N; i++) step(0, 1, 0, 0, 0, "R3");
    // R5 down steps at empty
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, "R5");
    // R9 external bit pattern
    step(0, 1, 0, 1, 5, "R9"); step(0, 1, 0, 1, 0, "R9");
    step(0, 1, 0, 0, 7, "R9"); step(0, 1, 0, 1, 0, "R9");
    step(0, 1, 0, 0, 0, "R9"); step(0, 1, 0, 0, 6, "R9");
    step(0, 1, 0, 1, 0, "R9"); step(0, 1, 0, 1, 0, "R9");
    // R7 frozen mid-range in encoder mode
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, "R7");
    // R8 encoder toward target 4
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 4, "R8");
    // R10 constant target: level must alternate 3/4
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 1, 0, 4, "R10");
      #1;
      if (prevLvl >= 0) cmp("R10", "level moved", (int'(level) != prevLvl) ? 1 : 0, 1);
      cmp("R10", "level in {3,4}", (level == 3 || level == 4) ? 1 : 0, 1);
      prevLvl = int'(level);
    end
    // R8 encoder toward 0, then toward 7 (above N)
    for (int i = 0; i < 7; i++) step(0, 1, 1, 1, 0, "R8");
    for (int i = 0; i < 9; i++) step(0, 1, 1, 0, 7, "R8");
    // R1 reset during activity
    step(1, 1, 1, 0, 7, "R1");
    step(0, 0, 1, 0, 7, "R1");
    step(0, 1, 1, 0, 2, "R8");
    step(0, 1, 1, 0, 2, "R8");
    step(0, 1, 1, 0, 2, "R8");
    step(0, 0, 0, 0, 0, "R7");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule